// File: doc/BRIEF.md
# Configurable Cache Hit/Miss Tracker

This block models only the tag side of a data cache. A stream of byte addresses goes in, one per cycle, and for each one the block reports one cycle later whether it hit or missed. It also keeps a running count of accesses and of hits. No data is stored, and there is no refill path.

The geometry is chosen at run time through configuration inputs:
- associativity of 1, 2 or 4 ways;
- block size from 1 to 32 bytes in powers of two;
- total capacity of 256 or 512 bytes;
- LRU or FIFO replacement.

Software or a surrounding model sets the configuration and then pulses `clr`. This empties the tag store and zeroes both counters. The block is then ready to measure a new address sequence. The hit ratio for a candidate cache shape can be read directly from the two counters.

Top module: `cache_tracker`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, both counters read zero, `res_valid` is low and every line is invalid, so the next access to any address misses.
- R2: The line address is `acc_addr >> cfg_blk`, where `cfg_blk` is log2 of the block size (0 to 5). The set count is capacity / (block × ways), with capacity 256 bytes when `cfg_cap`=0 and 512 bytes when it is 1. The set is the line address modulo the set count. `cfg_ways` is log2 of the associativity (0, 1 or 2).
- R3: An access presented with `acc_valid` high and `clr` low yields `res_valid` high on the next cycle. `res_hit` is 1 when the line address was resident in its set.
- R4: Each reported result raises `acc_count` by one. Each reported hit also raises `hit_count` by one. Neither counter changes otherwise.
- R5: On a miss in a set that still holds an invalid way, the new line takes a free way and no resident line is lost.
- R6: With `cfg_fifo`=0 (LRU), a hit makes the line the most recent. A miss in a full set evicts the least recently used line.
- R7: With `cfg_fifo`=1 (FIFO), a hit leaves the order unchanged. A miss in a full set evicts the line that was filled earliest.
- R8: An access presented while `clr` is high is ignored. It produces no result, is not counted and installs no line.
- R9: With one way, two line addresses that map to the same set displace each other on every alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Invalidate all lines and zero counters |
| acc_valid | input | 1 | Address strobe |
| acc_addr | input | ADDR_W | Byte address |
| cfg_ways | input | 2 | log2 of associativity (0..2) |
| cfg_blk | input | 3 | log2 of block size in bytes (0..5) |
| cfg_cap | input | 1 | 0: 256 bytes, 1: 512 bytes |
| cfg_fifo | input | 1 | 0: LRU, 1: FIFO |
| res_valid | output | 1 | Result strobe, one cycle after the access |
| res_hit | output | 1 | Hit flag for the reported access |
| acc_count | output | CNT_W | Accesses since clear |
| hit_count | output | CNT_W | Hits since clear |

## Verification
The assertions assume two things. First, the configuration inputs stay in their legal ranges. Second, the configuration changes only together with a `clr` pulse, so that a tag stored under one geometry is never compared under another. They also assume fewer accesses per clear than the counter width can hold, so that `hit_count <= acc_count` never fails because of a wrap. The stimulus respects all three: it reconfigures only inside its configure step, which always pulses `clr`; it sweeps only the legal codes; and it runs at most a few hundred accesses between clears.

// File: rtl/cache_tracker.sv
module cache_tracker #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int MAX_LINES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        cfg_ways,
  input  logic [2:0]        cfg_blk,
  input  logic              cfg_cap,
  input  logic              cfg_fifo,
  output logic              res_valid,
  output logic              res_hit,
  output logic [CNT_W-1:0]  acc_count,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int MAX_WAYS = 4;
  localparam int LINE_W   = $clog2(MAX_LINES);
  localparam int AGE_W    = $clog2(MAX_WAYS);

  logic [ADDR_W-1:0]    tag_q [MAX_LINES];
  logic [AGE_W-1:0]     age_q [MAX_LINES];
  logic [MAX_LINES-1:0] vld_q;

  logic [1:0]        lg_ways;
  logic [3:0]        lg_sets;
  logic [ADDR_W-1:0] line_addr;
  logic [LINE_W-1:0] set_mask, base;
  logic [AGE_W-1:0]  oldest;

  assign lg_ways   = (cfg_ways > 2'd2) ? 2'd2 : cfg_ways;
  assign lg_sets   = 4'd8 + {3'b0, cfg_cap} - {1'b0, cfg_blk} - {2'b0, lg_ways};
  assign line_addr = acc_addr >> cfg_blk;
  assign set_mask  = (LINE_W'(1) << lg_sets) - LINE_W'(1);
  assign base      = (line_addr[LINE_W-1:0] & set_mask) << lg_ways;
  assign oldest    = AGE_W'((1 << lg_ways) - 1);

  logic [LINE_W-1:0] idx  [MAX_WAYS];
  logic [AGE_W-1:0]  age  [MAX_WAYS];
  logic [MAX_WAYS-1:0] en, hitv, freev, oldv;

  for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
    assign idx[w]   = base | LINE_W'(w);
    assign age[w]   = age_q[idx[w]];
    assign en[w]    = w < (1 << lg_ways);
    assign hitv[w]  = en[w] && vld_q[idx[w]] && (tag_q[idx[w]] == line_addr);
    assign freev[w] = en[w] && !vld_q[idx[w]];
    assign oldv[w]  = en[w] && (age[w] == oldest);
  end

  logic             hit;
  logic [AGE_W-1:0] hit_way, free_way, old_way, tgt_way, hit_age;

  assign hit = |hitv;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    old_way  = '0;
    for (int w = MAX_WAYS - 1; w >= 0; w--) begin
      if (hitv[w])  hit_way  = AGE_W'(w);
      if (freev[w]) free_way = AGE_W'(w);
      if (oldv[w])  old_way  = AGE_W'(w);
    end
  end

  assign tgt_way = hit ? hit_way : (|freev ? free_way : old_way);
  assign hit_age = age[hit_way];

  logic              upd;
  logic [AGE_W-1:0]  age_nx [MAX_WAYS];

  assign upd = acc_valid && !clr && (!hit || !cfg_fifo);

  always_comb begin
    for (int w = 0; w < MAX_WAYS; w++) begin
      age_nx[w] = age[w];
      if (AGE_W'(w) == tgt_way)
        age_nx[w] = '0;
      else if (hit ? (age[w] < hit_age) : (age[w] != oldest))
        age_nx[w] = age[w] + AGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      vld_q     <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      acc_count <= '0;
      hit_count <= '0;
    end else begin
      res_valid <= acc_valid;
      res_hit   <= acc_valid && hit;
      if (acc_valid) begin
        acc_count <= acc_count + CNT_W'(1);
        if (hit) hit_count <= hit_count + CNT_W'(1);
      end
      if (upd) begin
        for (int w = 0; w < MAX_WAYS; w++) begin
          if (en[w]) age_q[idx[w]] <= age_nx[w];
        end
        if (!hit) begin
          vld_q[idx[tgt_way]] <= 1'b1;
          tag_q[idx[tgt_way]] <= line_addr;
        end
      end
    end
  end
endmodule

// File: rtl/cache_tracker_chk.sv
module cache_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             acc_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [CNT_W-1:0] acc_count,
  input logic [CNT_W-1:0] hit_count
);
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_count == '0 && hit_count == '0 && !res_valid)); // R1

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !clr) |=> res_valid); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || clr) |=> !res_valid); // R8

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    res_valid |-> acc_count == $past(acc_count) + CNT_W'(1)); // R4

  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    res_valid |-> hit_count == $past(hit_count) + CNT_W'(res_hit)); // R4

  AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= acc_count); // R4
endmodule

bind cache_tracker cache_tracker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cache_tracker_bench.sv
module cache_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr = 1'b0, acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  cfg_ways = '0;
  logic [2:0]  cfg_blk = '0;
  logic        cfg_cap = 1'b0, cfg_fifo = 1'b0;
  logic        res_valid, res_hit;
  logic [15:0] acc_count, hit_count;

  always #5 clk = ~clk;

  cache_tracker u_cache_tracker (.*);

  int checks = 0, errors = 0;
  bit    exp_hit_q[$];
  int    exp_acc_q[$], exp_hits_q[$];
  string exp_tag_q[$];
  int ref_ln[512][4];
  int ref_n[512];
  int cw, cb, cc, cf, r_acc, r_hit;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(int lw, int lb, int cap, int fifo);
    cw = lw; cb = lb; cc = cap; cf = fifo;
    cfg_ways = 2'(lw); cfg_blk = 3'(lb); cfg_cap = cap[0]; cfg_fifo = fifo[0];
    acc_valid = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int s = 0; s < 512; s++) ref_n[s] = 0;
    r_acc = 0; r_hit = 0;
    check(acc_count == 0 && hit_count == 0, "R1", "counters after clear", int'(acc_count) + int'(hit_count), 0);
  endtask

  task automatic access(int a);
    int sets, ways, ln, s, p;
    string tag;
    acc_valid = 1'b1; acc_addr = 16'(a);
    ways = 1 << cw;
    sets = (256 << cc) >> (cb + cw);
    ln = a >> cb;
    s = ln % sets;
    p = -1;
    for (int i = 0; i < ref_n[s]; i++) if (ref_ln[s][i] == ln) p = i;
    if (p >= 0) begin
      tag = cf ? "R7" : "R6";
      if (cf == 0) begin
        for (int i = p; i > 0; i--) ref_ln[s][i] = ref_ln[s][i-1];
        ref_ln[s][0] = ln;
      end
    end else begin
      if (ref_n[s] < ways) begin
        tag = "R5";
        ref_n[s]++;
      end else tag = cf ? "R7" : "R6";
      for (int i = ref_n[s] - 1; i > 0; i--) ref_ln[s][i] = ref_ln[s][i-1];
      ref_ln[s][0] = ln;
    end
    if (cw == 0) tag = "R9";
    r_acc++;
    if (p >= 0) r_hit++;
    exp_hit_q.push_back(p >= 0);
    exp_acc_q.push_back(r_acc);
    exp_hits_q.push_back(r_hit);
    exp_tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    acc_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_hit_q.size() == 0) begin
        check(1'b0, "R3", "unexpected result", 1, 0);
      end else begin
        automatic bit    eh = exp_hit_q.pop_front();
        automatic int    ea = exp_acc_q.pop_front();
        automatic int    ehc = exp_hits_q.pop_front();
        automatic string tg = exp_tag_q.pop_front();
        check(res_hit == eh, tg, "R2 R3 hit flag", int'(res_hit), int'(eh));
        check(acc_count == 16'(ea), "R4", "access count", int'(acc_count), ea);
        check(hit_count == 16'(ehc), "R4", "hit count", int'(hit_count), ehc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0 && acc_count == 0 && hit_count == 0, "R1", "reset state",
          int'(res_valid) + int'(acc_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // LRU vs FIFO: 2-way, 1-byte blocks, 256 B -> 128 sets
    configure(1, 0, 0, 0);
    access(0); access(128); access(0); access(256); access(0);
    idle(2);
    check(hit_count == 2, "R6", "LRU keeps refreshed line", int'(hit_count), 2);
    configure(1, 0, 0, 1);
    access(0); access(128); access(0); access(256); access(0);
    idle(2);
    check(hit_count == 1, "R7", "FIFO evicts oldest fill", int'(hit_count), 1);

    // direct-mapped conflict
    configure(0, 2, 0, 0);
    access(0); access(256); access(0); access(256);
    idle(2);
    check(hit_count == 0, "R9", "direct-mapped ping-pong", int'(hit_count), 0);

    // clear with simultaneous access
    configure(2, 3, 1, 0);
    access(40); access(40);
    acc_valid = 1'b1; acc_addr = 16'd40; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; acc_valid = 1'b0;
    check(res_valid == 1'b0 && acc_count == 0, "R8", "access during clear", int'(acc_count), 0);
    for (int s = 0; s < 512; s++) ref_n[s] = 0;
    r_acc = 0; r_hit = 0;
    access(40);
    idle(2);
    check(hit_count == 0 && acc_count == 1, "R1", "line gone after clear", int'(hit_count), 0);

    // fixed sequences under every geometry and policy, then pseudo-random stream
    lfsr = 16'hACE1;
    for (int lw = 0; lw < 3; lw++)
      for (int lb = 0; lb < 6; lb++)
        for (int cap = 0; cap < 2; cap++)
          for (int f = 0; f < 2; f++) begin
            configure(lw, lb, cap, f);
            access(0); access(2); access(4); access(8); access(16); access(32);
            access(0); access(512); access(1024); access(0); access(1536);
            access(0); access(2048); access(512);
            for (int k = 0; k < 150; k++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              access(int'(lfsr[10:0]) & ((lfsr[0]) ? 1023 : 4095));
            end
            idle(2);
            check(acc_count == 16'(r_acc), "R4", "final access count", int'(acc_count), r_acc);
          end

    idle(2);
    check(exp_hit_q.size() == 0, "R3", "missing results", exp_hit_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule